// File: doc/BRIEF.md
# Occupancy-Driven Clock Frequency Governor

This block sets the frequency of one clock domain from how busy that domain is. On every cycle it adds the current number of valid entries in the domain's issue queue to a running total. It also counts retired instructions, from zero to four per cycle. After every fixed number of retired instructions, called an interval, it compares the total for that interval with the total for the interval before it. It then adjusts a 16-bit unsigned fixed-point frequency code.

A relative change above 1.7 % in either direction is treated as significant. On a significant change the code moves by about 7 %: it goes up when occupancy rose and down when it fell. Without a significant change the code slowly decays by about 0.17 %. The result is always kept within a minimum and a maximum limit supplied from outside. A one-cycle strobe marks each new code. Each clock domain has its own instance of this block.

Top module: `freq_governor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `freq_code` equals `RESET_CODE` (16384 by default) and `freq_upd` is 0.
- R2: `retire_cnt` is added to a retired-instruction count on every cycle. An interval ends in the cycle where the count reaches or passes `INTERVAL` (10000). Any excess above `INTERVAL` carries into the next interval. The occupancy total of an interval includes the occupancy of its final cycle. When `retire_cnt` is 0, no interval ends.
- R3: The first interval after reset only records its total as the reference. It produces no strobe and leaves the code unchanged.
- R4: A change is significant only when |T - P| * 1000 > P * 17, where T is the current total and P is the previous total. A change of exactly 1.7 % is not significant.
- R5: On a significant rise (T > P), the code becomes code + max(1, (code * 287) >> 12).
- R6: On a significant fall, the code becomes code - max(1, (code * 287) >> 12).
- R7: When the change is not significant, the code becomes code - max(1, (code * 7) >> 12).
- R8: The adjusted code is clamped: a value above `max_code` becomes `max_code`, and a value below `min_code` becomes `min_code`.
- R9: `freq_upd` is high for exactly one cycle, on the cycle after each evaluating interval end, which is when the new code first appears. `freq_code` changes on no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occupancy | input | OCC_W (6) | Valid entries in the issue queue this cycle |
| retire_cnt | input | RET_W (3) | Instructions retired this cycle, 0 to 4 |
| min_code | input | CODE_W (16) | Lower limit of the frequency code |
| max_code | input | CODE_W (16) | Upper limit of the frequency code |
| freq_code | output | CODE_W (16) | Current frequency code |
| freq_upd | output | 1 | One-cycle strobe marking a new code |

## Verification
Several occupancy patterns are used, and each one separates different decisions:
- Constant occupancy across intervals separates decay from attack.
- A step up and a series of steps down separate the attack direction, and push the code into both clamp limits.
- An interval crafted to be exactly 1.7 % above its predecessor separates the strict threshold from a non-strict one.
- A second crafted interval, just above the threshold, confirms that the attack is taken there.
- Mixed retire counts and random occupancy move the interval boundaries off the four-per-cycle grid, so the carried excess and the inclusion of the final cycle's occupancy are both tested.
- A stretch with no retirements must produce no evaluation at all.

// File: rtl/freq_governor.sv
module freq_governor #(
  parameter int OCC_W      = 6,
  parameter int RET_W      = 3,
  parameter int INTERVAL   = 10000,
  parameter int CODE_W     = 16,
  parameter int RESET_CODE = 16384,
  parameter int THR_NUM    = 17,
  parameter int THR_DEN    = 1000,
  parameter int ATK_MUL    = 287,
  parameter int DCY_MUL    = 7,
  parameter int STEP_SH    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OCC_W-1:0]  occupancy,
  input  logic [RET_W-1:0]  retire_cnt,
  input  logic [CODE_W-1:0] min_code,
  input  logic [CODE_W-1:0] max_code,
  output logic [CODE_W-1:0] freq_code,
  output logic              freq_upd
);
  localparam int CNT_W  = $clog2(INTERVAL + 8);
  localparam int ACC_W  = OCC_W + CNT_W + 2;
  localparam int CMP_W  = ACC_W + 12;
  localparam int PROD_W = CODE_W + 10;
  localparam logic [CNT_W:0] INT_V = (CNT_W+1)'(INTERVAL);

  logic [CNT_W-1:0] cnt;
  logic [ACC_W-1:0] acc, prev;
  logic             have_ref;

  wire [CNT_W:0] cnt_sum = {1'b0, cnt} + (CNT_W+1)'(retire_cnt);
  wire           last    = cnt_sum >= INT_V;

  wire [ACC_W:0]   acc_ext = {1'b0, acc} + (ACC_W+1)'(occupancy);
  wire [ACC_W-1:0] total   = acc_ext[ACC_W] ? '1 : acc_ext[ACC_W-1:0];

  wire [ACC_W-1:0] delta  = (total >= prev) ? total - prev : prev - total;
  wire [CMP_W-1:0] lhs    = CMP_W'(delta) * CMP_W'(THR_DEN);
  wire [CMP_W-1:0] rhs    = CMP_W'(prev) * CMP_W'(THR_NUM);
  wire             signif = lhs > rhs;
  wire             rising = total > prev;

  wire [PROD_W-1:0] atk_p   = PROD_W'(freq_code) * PROD_W'(ATK_MUL);
  wire [PROD_W-1:0] dcy_p   = PROD_W'(freq_code) * PROD_W'(DCY_MUL);
  wire [CODE_W-1:0] atk_raw = CODE_W'(atk_p >> STEP_SH);
  wire [CODE_W-1:0] dcy_raw = CODE_W'(dcy_p >> STEP_SH);
  wire [CODE_W-1:0] atk_st  = (atk_raw == '0) ? CODE_W'(1) : atk_raw;
  wire [CODE_W-1:0] dcy_st  = (dcy_raw == '0) ? CODE_W'(1) : dcy_raw;
  wire [CODE_W-1:0] step    = signif ? atk_st : dcy_st;

  wire [CODE_W:0] up_sum = {1'b0, freq_code} + {1'b0, step};
  wire [CODE_W:0] dn_val = (freq_code >= step) ? {1'b0, freq_code - step} : '0;
  wire [CODE_W:0] cand   = (signif && rising) ? up_sum : dn_val;
  wire [CODE_W-1:0] next_code =
    (cand > {1'b0, max_code}) ? max_code :
    (cand < {1'b0, min_code}) ? min_code : cand[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      acc       <= '0;
      prev      <= '0;
      have_ref  <= 1'b0;
      freq_code <= CODE_W'(RESET_CODE);
      freq_upd  <= 1'b0;
    end else begin
      freq_upd <= 1'b0;
      if (last) begin
        cnt      <= CNT_W'(cnt_sum - INT_V);
        acc      <= '0;
        prev     <= total;
        have_ref <= 1'b1;
        if (have_ref) begin
          freq_code <= next_code;
          freq_upd  <= 1'b1;
        end
      end else begin
        cnt <= CNT_W'(cnt_sum);
        acc <= total;
      end
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < INT_V);

  assert_no_first_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    freq_upd |-> $past(have_ref));

  assert_in_limits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freq_upd |-> (freq_code <= $past(max_code) && freq_code >= $past(min_code)));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freq_upd |=> !freq_upd);

  assert_code_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_upd |-> $stable(freq_code));
endmodule

// File: tb/freq_governor_tb.sv
module freq_governor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  occupancy = '0;
  logic [2:0]  retire_cnt = '0;
  logic [15:0] min_code = 16'h3A00;
  logic [15:0] max_code = 16'h4300;
  logic [15:0] freq_code;
  logic        freq_upd;

  int checks = 0, errors = 0, cycles = 0;
  longint m_cnt, m_acc, m_prev, m_code;
  bit m_ref, m_upd;
  string m_tag = "R1";
  int hit_up = 0, hit_dn = 0, hit_dcy = 0, hit_edge = 0, hit_max = 0, hit_min = 0;

  always #2 clk = ~clk;

  freq_governor dut_i (
    .clk(clk), .rst_n(rst_n), .occupancy(occupancy), .retire_cnt(retire_cnt),
    .min_code(min_code), .max_code(max_code), .freq_code(freq_code), .freq_upd(freq_upd));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_acc = 0; m_prev = 0; m_ref = 0; m_code = 16384; m_upd = 0;
    end else begin
      longint tot, d, step, cand;
      bit sig;
      m_upd = 0;
      tot = m_acc + occupancy;
      m_cnt += retire_cnt;
      if (m_cnt >= 10000) begin
        m_cnt -= 10000;
        if (!m_ref) begin
          m_ref = 1;
          m_tag = "R3";
        end else begin
          d = (tot > m_prev) ? tot - m_prev : m_prev - tot;
          sig = d * 1000 > m_prev * 17;
          if (d * 1000 == m_prev * 17) hit_edge++;
          step = sig ? (m_code * 287) >> 12 : (m_code * 7) >> 12;
          if (step == 0) step = 1;
          if (sig && tot > m_prev) begin cand = m_code + step; hit_up++; m_tag = "R5"; end
          else begin
            cand = m_code - step;
            if (sig) begin hit_dn++; m_tag = "R6"; end
            else begin hit_dcy++; m_tag = "R7"; end
          end
          if (cand > max_code) begin cand = max_code; hit_max++; m_tag = "R8"; end
          else if (cand < min_code) begin cand = min_code; hit_min++; m_tag = "R8"; end
          m_code = cand;
          m_upd = 1;
        end
        m_prev = tot;
        m_acc = 0;
      end else m_acc = tot;
    end
  end

  always @(posedge clk) begin
    #1;
    cycles++;
    if (rst_n) begin
      check(freq_upd == m_upd, "R9/R2 strobe", freq_upd, m_upd);
      check(freq_code == m_code, m_tag, freq_code, m_code);
    end
    if (cycles > 200000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_iv(input int base, input int hi, input int nhi);
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      occupancy  = 6'((i < nhi) ? hi : base);
      retire_cnt = 3'd4;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(freq_code == 16384 && freq_upd == 0, "R1", freq_code, 16384);
    rst_n = 1'b1;
    run_iv(20, 20, 0);       // reference only (R3)
    run_iv(40, 40, 0);       // attack up, clamps at max (R5, R8)
    run_iv(40, 40, 0);       // decay (R7)
    run_iv(40, 41, 1700);    // exactly 1.7 %: decay (R4)
    run_iv(41, 42, 929);     // just above: attack up (R4, R5)
    run_iv(30, 30, 0);       // attack down (R6)
    run_iv(20, 20, 0);
    run_iv(12, 12, 0);       // reaches min (R8)
    run_iv(8, 8, 0);
    run_iv(8, 8, 0);
    for (int i = 0; i < 16000; i++) begin   // carry across boundaries (R2)
      @(negedge clk);
      occupancy  = 6'($urandom_range(63));
      retire_cnt = 3'(i % 5);
    end
    for (int i = 0; i < 60; i++) begin      // no retirement, no evaluation (R2)
      @(negedge clk);
      occupancy  = 6'd63;
      retire_cnt = 3'd0;
    end
    @(negedge clk);
    check(hit_edge > 0, "R4 boundary", hit_edge, 1);
    check(hit_up > 0, "R5", hit_up, 1);
    check(hit_dn > 0, "R6", hit_dn, 1);
    check(hit_dcy > 0, "R7", hit_dcy, 1);
    check(hit_max > 0, "R8 max", hit_max, 1);
    check(hit_min > 0, "R8 min", hit_min, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule